// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor core that completes one 32-bit instruction on every clock. On each cycle the program counter addresses an internal read-only instruction store. A combinational decoder turns the opcode, and for register-register forms the function field, into five datapath controls and an ALU operation. The core reads two operands from a 32-entry register file. The ALU combines the first operand with either the second register or a sign-extended 16-bit immediate. On the next rising edge the result goes either into the register file or into a single-ported data store.

Four instruction shapes are handled: register-register arithmetic, register-immediate arithmetic, word load and word store. The register destination comes from the rd field for register-register forms and from the rt field for every other form. A testbench fills the instruction store through the task `preload_instr` while reset is held. The register-file write port and the data-store port are brought out as outputs, so that each instruction's effect can be observed.

Top module: `sc_core`

## Requirements
- R1: While rst_n is low at a rising edge, the program counter is set to 0. On every rising edge with rst_n high it advances by 4. The instruction store is indexed by pc[7:2], which is a word address.
- R2: The instruction layout is opcode[31:26], rs[25:21], rt[20:16], rd[15:11], imm[15:0] and funct[5:0]. Opcode 0x00 selects register-register forms, with funct 0x20 ADD, 0x22 SUB, 0x24 AND and 0x25 OR. Each writes rs op rt into register rd.
- R3: Opcodes 0x08 (add), 0x0C (and) and 0x0D (or) write rs op sign_extend(imm) into register rt. The immediate is sign-extended even for the logical forms.
- R4: Opcode 0x23 loads. It presents rs + sign_extend(imm) on dm_addr_o and writes the data-store word at that byte address into register rt.
- R5: Opcode 0x2B stores. It writes register rt to the data store at rs + sign_extend(imm) and raises dm_we_o. rf_we_o stays low.
- R6: Register 0 always reads as zero. A write aimed at register 0 leaves it zero.
- R7: An unknown opcode, or opcode 0x00 with an unknown funct (0x00 included), drives rf_we_o and dm_we_o low, so the instruction changes no state.
- R8: A synchronous reset clears every register of the register file to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write enable of the current instruction |
| rf_waddr_o | output | 5 | Register write address (rd or rt) |
| rf_wdata_o | output | 32 | Register write data (ALU result or loaded word) |
| dm_we_o | output | 1 | Data-store write enable |
| dm_addr_o | output | 32 | Data-store byte address (ALU result) |
| dm_wdata_o | output | 32 | Data-store write data (register rt) |

## Verification
If a register holds a wrong value, nothing shows at the ports until a later instruction reads it. The program therefore chains results: sums feed stores, and stores feed loads. A corrupt register then appears on rf_wdata_o or dm_wdata_o within one to three instructions of the faulty write. A wrong control decode appears in the same cycle as the instruction, as a wrong write enable or a wrong destination field on rf_waddr_o. A program counter that fails to advance or to reset shows directly on pc_o.

// File: rtl/sc_pkg.sv
// Package: shared opcode, function and control types for the single-cycle core.
// Assumes the 32-bit instruction layout described in the brief.
package sc_pkg;

    localparam int INSTR_W = 32;
    localparam int RF_AW   = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_ANDI  = 6'h0C;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic    dst_rd;     // 1: write address from rd, 0: from rt
        logic    src_imm;    // 1: second operand is the immediate
        logic    wb_mem;     // 1: write data from the data store
        logic    mem_wr;     // data-store write enable
        logic    reg_wr;     // register-file write enable
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
// Module: sc_decoder
// Maps opcode and funct to the five datapath controls and an ALU operation.
// Assumes: purely combinational; any unknown code yields no writes.
module sc_decoder
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Decode the instruction class and, for register forms, the function.
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (opcode)
            OP_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_wr = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    default: ctrl.reg_wr = 1'b0;
                endcase
            end
            OP_ADDI: begin
                ctrl.src_imm = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.alu_op  = ALU_ADD;
            end
            OP_ANDI: begin
                ctrl.src_imm = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.alu_op  = ALU_AND;
            end
            OP_ORI: begin
                ctrl.src_imm = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            OP_LOAD: begin
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.reg_wr  = 1'b1;
            end
            OP_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
// Module: sc_alu
// Two-operand arithmetic and logic unit of width W.
// Assumes: combinational, wrap-around arithmetic with no flags.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    // Select the result for the requested operation.
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            default: y = a | b;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
// Module: sc_regfile
// Register file with two asynchronous read ports and one write port.
// Assumes: entry 0 reads as zero and ignores writes; synchronous active-low
// reset clears all entries.
module sc_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [DEPTH];

    // Clear on reset, otherwise commit the single write unless aimed at entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Read ports: entry 0 is hard-wired to zero.
    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/sc_core.sv
// Module: sc_core (top)
// Single-cycle core: PC, instruction store, decoder, register file, ALU,
// sign extender and a single-ported data store.
// Assumes: the instruction store is filled through preload_instr while reset
// is held; memories are word-indexed by address bits above bit 1.
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IMEM_AW   = $clog2(IMEM_WORDS),
    localparam int DMEM_AW   = $clog2(DMEM_WORDS),
    localparam int RF_DEPTH  = 1 << RF_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [XLEN-1:0]  pc_o,
    output logic             rf_we_o,
    output logic [RF_AW-1:0] rf_waddr_o,
    output logic [XLEN-1:0]  rf_wdata_o,
    output logic             dm_we_o,
    output logic [XLEN-1:0]  dm_addr_o,
    output logic [XLEN-1:0]  dm_wdata_o
);

    logic [INSTR_W-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0]    dmem [DMEM_WORDS];

    logic [XLEN-1:0]    pc_q;
    logic [INSTR_W-1:0] instr;
    ctrl_t              ctrl;
    logic [RF_AW-1:0]   rs_addr, rt_addr, rd_addr;
    logic [XLEN-1:0]    rs_data, rt_data, imm_ext, alu_b, alu_y, mem_rdata;
    logic [DMEM_AW-1:0] dm_idx;

    // Backdoor fill of the instruction store (testbench use only).
    task automatic preload_instr(input int idx, input logic [INSTR_W-1:0] word);
        imem[idx] = word;
    endtask

    // Program counter: cleared by reset, otherwise steps one word.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_q + XLEN'(4);
    end

    assign instr   = imem[pc_q[IMEM_AW+1:2]];
    assign rs_addr = instr[25:21];
    assign rt_addr = instr[20:16];
    assign rd_addr = instr[15:11];
    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

    sc_decoder u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    sc_regfile #(.W(XLEN), .DEPTH(RF_DEPTH)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (rs_addr),
        .ra_b  (rt_addr),
        .rd_a  (rs_data),
        .rd_b  (rt_data),
        .we    (ctrl.reg_wr),
        .wa    (rf_waddr_o),
        .wd    (rf_wdata_o)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : rt_data;

    sc_alu #(.W(XLEN)) u_alu (
        .op (ctrl.alu_op),
        .a  (rs_data),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign dm_idx    = alu_y[DMEM_AW+1:2];
    assign mem_rdata = dmem[dm_idx];

    // Data store: single port, written on the clock edge when enabled.
    always_ff @(posedge clk) begin
        if (rst_n && ctrl.mem_wr) dmem[dm_idx] <= rt_data;
    end

    assign pc_o       = pc_q;
    assign rf_we_o    = ctrl.reg_wr;
    assign rf_waddr_o = ctrl.dst_rd ? rd_addr : rt_addr;
    assign rf_wdata_o = ctrl.wb_mem ? mem_rdata : alu_y;
    assign dm_we_o    = ctrl.mem_wr;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_data;

endmodule

// File: rtl/sc_core_checker.sv
// Module: sc_core_checker
// Concurrent properties for sc_core, attached with bind below.
module sc_core_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc,
    input logic [31:0]     instr,
    input logic            rf_we,
    input logic [4:0]      rf_waddr,
    input logic            dm_we,
    input logic [4:0]      rs_addr,
    input logic [XLEN-1:0] rs_data
);

    logic op_known, op_imm_dst, fn_known;
    assign op_known   = instr[31:26] inside {6'h00, 6'h08, 6'h0C, 6'h0D, 6'h23, 6'h2B};
    assign op_imm_dst = instr[31:26] inside {6'h08, 6'h0C, 6'h0D, 6'h23};
    assign fn_known   = instr[5:0] inside {6'h20, 6'h22, 6'h24, 6'h25};

    // R1: reset drives the program counter to zero.
    a_r1_pc_reset: assert property (@(posedge clk) !rst_n |=> pc == '0);

    // R1: out of reset the program counter steps by four.
    a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pc == $past(pc) + XLEN'(4));

    // R2: register-register forms write to rd.
    a_r2_rd_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == 6'h00 && rf_we) |-> rf_waddr == instr[15:11]);

    // R3: immediate and load forms write to rt.
    a_r3_rt_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (op_imm_dst && rf_we) |-> rf_waddr == instr[20:16]);

    // R5: a store never writes the register file.
    a_r5_store_no_regwr: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> !rf_we);

    // R6: register 0 reads as zero.
    a_r6_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_addr == 5'd0) |-> rs_data == '0);

    // R7: unknown opcodes make no writes.
    a_r7_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        !op_known |-> (!rf_we && !dm_we));

    // R7: unknown function codes make no writes.
    a_r7_bad_funct: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == 6'h00 && !fn_known) |-> (!rf_we && !dm_we));

endmodule

bind sc_core sc_core_checker #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc_o),
    .instr    (instr),
    .rf_we    (rf_we_o),
    .rf_waddr (rf_waddr_o),
    .dm_we    (dm_we_o),
    .rs_addr  (rs_addr),
    .rs_data  (rs_data)
);

// File: tb/sc_core_tb.sv
// Testbench for sc_core: a vector table of instructions and their expected
// port effects, then directed reset checks.
module sc_core_tb;

    typedef struct packed {
        logic [31:0] instr;
        logic        rf_we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        dm_we;
        logic        addr_chk;
        logic [31:0] da;
        logic [31:0] dd;
    } vec_t;

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rd,
                                          input logic [4:0] rs, input logic [4:0] rt);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rt,
                                          input logic [4:0] rs, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{enc_i(6'h08, 5'd1, 5'd0, 16'd5),      1'b1, 5'd1,  32'd5,        1'b0, 1'b0, 32'd0, 32'd0},
        '{enc_i(6'h08, 5'd2, 5'd0, 16'hFFFD),   1'b1, 5'd2,  32'hFFFFFFFD, 1'b0, 1'b0, 32'd0, 32'd0},
        '{enc_r(6'h20, 5'd3, 5'd1, 5'd2),       1'b1, 5'd3,  32'd2,        1'b0, 1'b0, 32'd0, 32'd0},
        '{enc_r(6'h22, 5'd4, 5'd1, 5'd2),       1'b1, 5'd4,  32'd8,        1'b0, 1'b0, 32'd0, 32'd0},
        '{enc_r(6'h24, 5'd5, 5'd1, 5'd2),       1'b1, 5'd5,  32'd5,        1'b0, 1'b0, 32'd0, 32'd0},
        '{enc_r(6'h25, 5'd6, 5'd1, 5'd2),       1'b1, 5'd6,  32'hFFFFFFFD, 1'b0, 1'b0, 32'd0, 32'd0},
        '{enc_i(6'h0D, 5'd7, 5'd0, 16'h8000),   1'b1, 5'd7,  32'hFFFF8000, 1'b0, 1'b0, 32'd0, 32'd0},
        '{enc_i(6'h0C, 5'd8, 5'd2, 16'h00F0),   1'b1, 5'd8,  32'h000000F0, 1'b0, 1'b0, 32'd0, 32'd0},
        '{enc_i(6'h2B, 5'd4, 5'd1, 16'd3),      1'b0, 5'd0,  32'd0,        1'b1, 1'b1, 32'd8, 32'd8},
        '{enc_i(6'h2B, 5'd7, 5'd4, 16'hFFFC),   1'b0, 5'd0,  32'd0,        1'b1, 1'b1, 32'd4, 32'hFFFF8000},
        '{enc_i(6'h23, 5'd9, 5'd4, 16'd0),      1'b1, 5'd9,  32'd8,        1'b0, 1'b1, 32'd8, 32'd0},
        '{enc_i(6'h23, 5'd10, 5'd3, 16'd2),     1'b1, 5'd10, 32'hFFFF8000, 1'b0, 1'b1, 32'd4, 32'd0},
        '{enc_i(6'h08, 5'd0, 5'd1, 16'd7),      1'b1, 5'd0,  32'd12,       1'b0, 1'b0, 32'd0, 32'd0},
        '{enc_r(6'h20, 5'd11, 5'd0, 5'd1),      1'b1, 5'd11, 32'd5,        1'b0, 1'b0, 32'd0, 32'd0},
        '{{6'h3F, 5'd1, 5'd2, 16'h0010},        1'b0, 5'd0,  32'd0,        1'b0, 1'b0, 32'd0, 32'd0},
        '{enc_r(6'h00, 5'd14, 5'd1, 5'd2),      1'b0, 5'd0,  32'd0,        1'b0, 1'b0, 32'd0, 32'd0},
        '{enc_r(6'h20, 5'd12, 5'd10, 5'd9),     1'b1, 5'd12, 32'hFFFF8008, 1'b0, 1'b0, 32'd0, 32'd0},
        '{enc_r(6'h22, 5'd13, 5'd0, 5'd1),      1'b1, 5'd13, 32'hFFFFFFFB, 1'b0, 1'b0, 32'd0, 32'd0}
    };

    // Requirement covered by each table row.
    localparam string ROW_REQ [NV] = '{"R3", "R3", "R2", "R2", "R2", "R2", "R3", "R3",
                                       "R5", "R5", "R4", "R4", "R6", "R6", "R7", "R7",
                                       "R4", "R2"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    sc_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Main sequence: preload, walk the table, then directed reset tests.
    initial begin
        for (int i = 0; i < 64; i++) u_dut.preload_instr(i, 32'd0);
        for (int i = 0; i < NV; i++) u_dut.preload_instr(i, VECS[i].instr);
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "pc in reset", pc_o, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            #1;
            chk("R1", $sformatf("pc row %0d", i), pc_o, 32'(i * 4));
            chk(ROW_REQ[i], $sformatf("rf_we row %0d", i), 32'(rf_we_o), 32'(VECS[i].rf_we));
            if (VECS[i].rf_we) begin
                chk(ROW_REQ[i], $sformatf("waddr row %0d", i), 32'(rf_waddr_o), 32'(VECS[i].wa));
                chk(ROW_REQ[i], $sformatf("wdata row %0d", i), rf_wdata_o, VECS[i].wd);
            end
            chk(ROW_REQ[i], $sformatf("dm_we row %0d", i), 32'(dm_we_o), 32'(VECS[i].dm_we));
            if (VECS[i].addr_chk)
                chk(ROW_REQ[i], $sformatf("dm_addr row %0d", i), dm_addr_o, VECS[i].da);
            if (VECS[i].dm_we)
                chk(ROW_REQ[i], $sformatf("dm_wdata row %0d", i), dm_wdata_o, VECS[i].dd);
            @(negedge clk);
        end
        // R8: reset mid-run clears registers; r1 and r2 held non-zero before.
        rst_n = 1'b0;
        u_dut.preload_instr(0, enc_r(6'h20, 5'd13, 5'd1, 5'd2));
        repeat (2) @(negedge clk);
        #1;
        chk("R1", "pc after mid-run reset", pc_o, 32'd0);
        rst_n = 1'b1;
        #1;
        chk("R8", "waddr after reset", 32'(rf_waddr_o), 32'd13);
        chk("R8", "sum of cleared registers", rf_wdata_o, 32'd0);
        @(negedge clk);
        #1;
        chk("R1", "pc first step after reset", pc_o, 32'd4);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 5000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule